// File: doc/BRIEF.md
# Serial ROM Responder for a Bit-Banged Two-Wire Bus

This block answers a host that drives a two-wire serial bus by writing clock and data levels into a software-controlled output register. Each time the host updates that register, the block receives a single-cycle update strobe carrying the new clock (SCL) and data (SDA) levels. It watches for a start condition, then shifts in a command byte and a word address, with an acknowledge slot after each byte. At the end of the address byte it fetches the addressed byte from a 256-byte read-only image.

The block keeps one resolved SDA level. That level is the host's value, or a forced acknowledge low, or a data bit from the block. The host reads it back through its input register. The block only serves reads: write data is never stored. The data register is loaded at the end of one transaction and shifted out during the address phase of the next read transaction.

Top module: `serial_rom_responder`

## Requirements
- R1: After reset the resolved SDA output is 1 and no acknowledge is pending, even when reset lands in the middle of a transaction.
- R2: A strobe where SCL is 1 both before and after while SDA goes from 1 to 0 is a start. It restarts the bit count at the first command bit and clears the command byte, also in the middle of a byte.
- R3: A strobe where SCL is 1 both before and after while SDA goes from 0 to 1 is a stop. It changes neither the bit count nor the pending acknowledge.
- R4: With no transaction open and no acknowledge pending, clock edges have no protocol effect, and the output simply follows the host's SDA.
- R5: Eight SCL rising edges with SDA held steady shift in the command byte, MSB first on the wire. The next rising edge is an acknowledge slot, and the output reads 0 in it.
- R6: In a read transaction (bit 0 of the command byte, the last command bit sent, equal to 1), each of the eight address-phase rising edges outputs the next bit, MSB first, of the byte fetched at the end of the previous transaction. That byte is 0 after reset.
- R7: After the eighth address bit the addressed byte is fetched, an acknowledge slot follows, and then the block returns to waiting for a start.
- R8: A strobe that raises SCL while also changing SDA takes no protocol action: no bit is shifted and the count does not advance.
- R9: The output is the last resolved SDA. It and the stored SCL change only on a strobe, and with SCL low the output equals the host's SDA.
- R10: In a write transaction (command bit 0 equal to 0), the address-phase rising edges output the host's SDA.
- R11: The default image holds 0x80, 0x08, 0x04, 0x0D at addresses 0x00 to 0x03, 0x12 and 0xD0 at 0x3E and 0x3F, 0x64 and 0xF4 at 0x7E and 0x7F, and zero elsewhere.
- R12: In an acknowledge slot the output is 0, even if SDA changes on the same strobe, and that edge shifts no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle strobe: the host updated its bus output levels |
| scl_i | input | 1 | New SCL level, valid with upd_i |
| sda_i | input | 1 | New SDA level, valid with upd_i |
| sda_o | output | 1 | Resolved SDA level presented for readback |

## Verification
Two cases can fall on the same strobe. The first is an acknowledge slot meeting a host that moves SDA on the same rising edge; there the forced low must win and no bit may be counted. The bench provokes this by changing SDA while raising SCL in the slot after the command byte. It then checks that the output is 0 and that the next acknowledge lands after exactly eight more address bits. The second case is the last data bit leaving on the same edge that reloads the data register from the image. The bench judges it by reading the final bit of one transaction and the first bit of the next.

// File: rtl/srom_pkg.sv
package srom_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int TICK_W   = $clog2(2 * BYTE_W + 2);
    localparam logic [TICK_W-1:0] CMD_DONE = TICK_W'(BYTE_W + 1);
    localparam logic [TICK_W-1:0] ADR_DONE = TICK_W'(2 * BYTE_W + 1);
    localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t image_t [DEPTH];

    // classification of one strobe against the stored line levels
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic steady;
    } line_ev_t;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        byte_t             cmd;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
        logic              ack;
        logic              scl;
        logic              sda;
    } eng_st_t;

    // presence-detect style default image, zero where not listed
    function automatic image_t default_image();
        image_t img;
        for (int i = 0; i < DEPTH; i++) begin
            img[i] = '0;
        end
        img[8'h00] = 8'h80;
        img[8'h01] = 8'h08;
        img[8'h02] = 8'h04;
        img[8'h03] = 8'h0D;
        img[8'h3E] = 8'h12;
        img[8'h3F] = 8'hD0;
        img[8'h7E] = 8'h64;
        img[8'h7F] = 8'hF4;
        return img;
    endfunction
endpackage

// File: rtl/srom_line_events.sv
module srom_line_events
    import srom_pkg::*;
(
    input  logic     scl_q,
    input  logic     sda_q,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic high_hold;
    logic moved;

    always_comb begin
        high_hold   = scl_q & scl_i;
        moved       = sda_q ^ sda_i;
        ev_o.start  = high_hold & moved & ~sda_i;
        ev_o.stop   = high_hold & moved & sda_i;
        ev_o.rise   = ~scl_q & scl_i;
        ev_o.steady = ~moved;
    end
endmodule

// File: rtl/srom_image_rom.sv
module srom_image_rom
    import srom_pkg::*;
#(
    parameter image_t IMAGE = default_image()
) (
    input  logic [ADDR_W-1:0] addr_i,
    output byte_t             data_o
);
    assign data_o = IMAGE[addr_i];
endmodule

// File: rtl/srom_engine.sv
module srom_engine
    import srom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              sda_i,
    input  logic              scl_i,
    input  line_ev_t          ev_i,
    input  byte_t             rom_data_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              line_scl_o,
    output logic              line_sda_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o
);
    eng_st_t st_d, st_q;
    logic    res_sda;
    logic [ADDR_W-1:0] addr_nxt;

    assign addr_nxt   = {st_q.addr[ADDR_W-2:0], sda_i};
    assign rom_addr_o = addr_nxt;

    always_comb begin
        st_d    = st_q;
        res_sda = sda_i;
        if (upd_i) begin
            if (ev_i.start) begin
                st_d.tick = TICK_ONE;
                st_d.cmd  = '0;
            end else if (ev_i.stop) begin
                st_d.tick = st_q.tick;
            end else if (st_q.tick == '0 && !st_q.ack) begin
                st_d.tick = st_q.tick;
            end else if (ev_i.rise) begin
                if (st_q.ack) begin
                    res_sda  = 1'b0;
                    st_d.ack = 1'b0;
                end else if (ev_i.steady) begin
                    if (st_q.tick < CMD_DONE) begin
                        st_d.cmd  = {st_q.cmd[BYTE_W-2:0], sda_i};
                        st_d.tick = st_q.tick + TICK_ONE;
                        if (st_q.tick + TICK_ONE == CMD_DONE) begin
                            st_d.ack = 1'b1;
                        end
                    end else if (st_q.tick < ADR_DONE) begin
                        if (st_q.cmd[0]) begin
                            res_sda = st_q.data[BYTE_W-1];
                        end
                        st_d.addr = addr_nxt;
                        st_d.data = {st_q.data[BYTE_W-2:0], 1'b0};
                        if (st_q.tick + TICK_ONE == ADR_DONE) begin
                            st_d.data = rom_data_i;
                            st_d.ack  = 1'b1;
                            st_d.tick = '0;
                        end else begin
                            st_d.tick = st_q.tick + TICK_ONE;
                        end
                    end
                end
            end
            st_d.scl = scl_i;
            st_d.sda = res_sda;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick <= '0;
            st_q.cmd  <= '0;
            st_q.addr <= '0;
            st_q.data <= '0;
            st_q.ack  <= 1'b0;
            st_q.scl  <= 1'b1;
            st_q.sda  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_scl_o = st_q.scl;
    assign line_sda_o = st_q.sda;
    assign tick_o     = st_q.tick;
    assign ack_o      = st_q.ack;
endmodule

// File: rtl/serial_rom_responder.sv
module serial_rom_responder
    import srom_pkg::*;
#(
    parameter image_t IMAGE = default_image()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);
    line_ev_t          ev_w;
    logic              line_scl;
    logic              line_sda;
    logic [TICK_W-1:0] tick_w;
    logic              ack_w;
    logic [ADDR_W-1:0] rom_addr;
    byte_t             rom_data;

    srom_line_events u_ev (
        .scl_q (line_scl),
        .sda_q (line_sda),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev_w)
    );

    srom_image_rom #(.IMAGE(IMAGE)) u_rom (
        .addr_i (rom_addr),
        .data_o (rom_data)
    );

    srom_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (upd_i),
        .sda_i      (sda_i),
        .scl_i      (scl_i),
        .ev_i       (ev_w),
        .rom_data_i (rom_data),
        .rom_addr_o (rom_addr),
        .line_scl_o (line_scl),
        .line_sda_o (line_sda),
        .tick_o     (tick_w),
        .ack_o      (ack_w)
    );

    assign sda_o = line_sda;
endmodule

// File: rtl/srom_checker.sv
module srom_checker
    import srom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              upd_i,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_o,
    input logic              line_scl,
    input logic [TICK_W-1:0] tick,
    input logic              ack
);
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && line_scl && scl_i && sda_o && !sda_i) |=> (tick == TICK_ONE)); // R2

    AST_STOP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && line_scl && scl_i && !sda_o && sda_i) |=> ($stable(tick) && $stable(ack))); // R3

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && tick == '0 && !ack && !(line_scl && scl_i && (sda_o != sda_i)))
        |=> (tick == '0 && !ack)); // R4

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tick < ADR_DONE); // R7

    AST_ACK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && ack && !line_scl && scl_i) |=> (!sda_o && !ack)); // R12

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(sda_o) && $stable(line_scl))); // R9

    AST_LOW_SCL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !scl_i) |=> (sda_o == $past(sda_i))); // R9
endmodule

bind serial_rom_responder srom_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_o    (sda_o),
    .line_scl (line_scl),
    .tick     (tick_w),
    .ack      (ack_w)
);

// File: tb/sim_serial_rom_responder.sv
`timescale 1ns/1ps
module sim_serial_rom_responder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_o;
    int   n_chk = 0;
    int   n_err = 0;

    always #2 clk = ~clk;

    serial_rom_responder u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (upd),
        .scl_i (scl),
        .sda_i (sda),
        .sda_o (sda_o)
    );

    // {read, command, address, byte shown during address phase}
    // shown bytes are image values from R11 fetched by the previous entry
    localparam logic [24:0] TXN [7] = '{
        {1'b1, 8'hA1, 8'h03, 8'h00},
        {1'b1, 8'hA1, 8'h3E, 8'h0D},
        {1'b1, 8'hA1, 8'h7F, 8'h12},
        {1'b1, 8'hA1, 8'h00, 8'hF4},
        {1'b0, 8'hA0, 8'h7E, 8'h00},
        {1'b1, 8'hA1, 8'h01, 8'h64},
        {1'b1, 8'hA1, 8'h02, 8'h08}
    };

    task automatic chk(input logic act, input logic exp, input string rq);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: sda_o actual=%b expected=%b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic strobe(input logic c, input logic d, input logic e, input string rq);
        @(negedge clk);
        upd = 1'b1; scl = c; sda = d;
        @(negedge clk);
        upd = 1'b0;
        chk(sda_o, e, rq);
    endtask

    task automatic bit_clk(input logic b, input logic hi_exp, input string rq);
        strobe(1'b0, b, b, rq);
        strobe(1'b1, b, hi_exp, rq);
    endtask

    task automatic start_cond();
        strobe(1'b0, 1'b1, 1'b1, "R4");
        strobe(1'b1, 1'b1, 1'b1, "R4");
        strobe(1'b1, 1'b0, 1'b0, "R2");
    endtask

    task automatic ack_slot(input string rq);
        strobe(1'b0, 1'b1, 1'b1, rq);
        strobe(1'b1, 1'b1, 1'b0, rq);
    endtask

    task automatic idle_pair();
        strobe(1'b0, 1'b1, 1'b1, "R7");
        strobe(1'b1, 1'b1, 1'b1, "R7");
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        for (int i = 7; i >= 0; i--) bit_clk(cmd[i], cmd[i], "R5");
    endtask

    task automatic send_addr(input logic rd, input logic [7:0] a, input logic [7:0] shown);
        for (int i = 7; i >= 0; i--) begin
            if (rd) bit_clk(a[i], shown[i], "R6 R11");
            else    bit_clk(a[i], a[i], "R10");
        end
    endtask

    task automatic run_txn(input logic [24:0] v);
        start_cond();
        send_cmd(v[23:16]);
        ack_slot("R5");
        send_addr(v[24], v[15:8], v[7:0]);
        ack_slot("R7");
        idle_pair();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_o, 1'b1, "R1");

        // table of transactions
        for (int t = 0; t < 7; t++) run_txn(TXN[t]);

        // R9: no strobe, no change
        scl = 1'b0; sda = 1'b0;
        repeat (5) @(negedge clk);
        chk(sda_o, 1'b1, "R9");

        // R4: clocking without a start has no effect
        for (int i = 0; i < 10; i++) bit_clk(i[0], i[0], "R4");
        for (int i = 0; i < 10; i++) bit_clk(1'b1, 1'b1, "R4");

        // R8: SDA moving with SCL rise is not counted
        start_cond();
        strobe(1'b0, 1'b0, 1'b0, "R8");
        strobe(1'b1, 1'b1, 1'b1, "R8");
        send_cmd(8'hA0);
        ack_slot("R8");

        // R3: stop mid-address keeps the count (write mirrors host)
        bit_clk(1'b1, 1'b1, "R10");
        bit_clk(1'b0, 1'b0, "R10");
        bit_clk(1'b1, 1'b1, "R10");
        strobe(1'b0, 1'b0, 1'b0, "R3");
        strobe(1'b1, 1'b0, 1'b0, "R3");
        strobe(1'b1, 1'b1, 1'b1, "R3");
        bit_clk(1'b0, 1'b0, "R3");
        bit_clk(1'b0, 1'b0, "R3");
        bit_clk(1'b1, 1'b1, "R3");
        bit_clk(1'b0, 1'b0, "R3");
        ack_slot("R3");
        idle_pair();

        // R12: ack slot wins over a moving SDA; data byte is image[0xA2] = 0
        start_cond();
        send_cmd(8'hA1);
        strobe(1'b0, 1'b0, 1'b0, "R12");
        strobe(1'b1, 1'b1, 1'b0, "R12");
        send_addr(1'b1, 8'h02, 8'h00);
        ack_slot("R12");
        idle_pair();

        // R2: restart in mid command byte
        start_cond();
        bit_clk(1'b1, 1'b1, "R2");
        bit_clk(1'b1, 1'b1, "R2");
        bit_clk(1'b1, 1'b1, "R2");
        strobe(1'b1, 1'b0, 1'b0, "R2");
        send_cmd(8'hA1);
        ack_slot("R2");
        send_addr(1'b1, 8'h3F, 8'h04);
        ack_slot("R7");
        idle_pair();
        run_txn({1'b1, 8'hA1, 8'h10, 8'hD0});

        // R1: reset while an acknowledge is pending
        start_cond();
        send_cmd(8'hA1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(sda_o, 1'b1, "R1");
        strobe(1'b0, 1'b1, 1'b1, "R1");
        strobe(1'b1, 1'b1, 1'b1, "R1");

        finish_run();
    end
endmodule